// File: doc/BRIEF.md
# DMA Request Arbiter with Bus Handshake

This block decides which of four peripheral DMA channels is served next, for a DMA controller that has to borrow the system bus from the CPU before it can move data. Each incoming request is qualified by that channel's enable bit. When at least one qualified request is present, the block asks the CPU for the bus with a hold request. It then waits until the CPU answers with hold acknowledge. Only after that does it drive one channel's acknowledge line.

The winner is chosen by a priority scheme that can be changed while the block runs. In fixed mode the lowest channel number always wins. In rotating mode the channel served most recently drops to the bottom of the order. The transfer sequencer sees which channel owns the bus and pulses a done input when that channel's service is over. At that point the block either hands the bus straight to the next qualified channel or lets go of the bus altogether.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held and right after it, hrq_o is 0, dack_o is 4'b0000 and active_o is 0.
- R2: A request whose enable bit (chan_en_i[i] for req_i[i]) is 0 never raises hrq_o and is never acknowledged.
- R3: From the idle state, a qualified request present at a clock edge makes hrq_o 1 after that edge.
- R4: No acknowledge is driven before hlda_i has been sampled high while hold is requested. The grant appears one cycle after that sample.
- R5: dack_o has at most one bit set, bit i standing for channel i, and it is nonzero only while hlda_i is 1.
- R6: With rotate_i = 0 (fixed), the qualified channel with the lowest index wins.
- R7: With rotate_i = 1 (rotating), the search starts at the channel after the one last served and wraps around. After reset the pointer makes channel 0 the first candidate.
- R8: If done_i is sampled in service while a qualified request remains, the next winner is acknowledged in the following cycle and hrq_o stays 1.
- R9: If done_i is sampled in service with no qualified request, hrq_o and dack_o go to 0 in the following cycle. Hold is not requested again until hlda_i has been seen low.
- R10: If every qualified request disappears while hold is requested and hlda_i is still 0, hrq_o falls after that edge.
- R11: While active_o is 1, active_ch_o gives the index of the single set dack_o bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 4 | Peripheral request lines, one per channel |
| chan_en_i | input | 4 | Per-channel enable mask |
| rotate_i | input | 1 | 1 selects rotating priority, 0 selects fixed |
| hlda_i | input | 1 | Hold acknowledge from the CPU |
| done_i | input | 1 | Sequencer pulse: current channel's service is over |
| hrq_o | output | 1 | Hold request to the CPU |
| dack_o | output | 4 | One-hot channel acknowledge |
| active_o | output | 1 | A channel currently owns the bus |
| active_ch_o | output | 2 | Index of the channel that owns the bus |

## Verification
Two things can happen on the same edge: the end of one channel's service and the arbitration for the next one. When that happens, the rotation pointer has to be updated before the new winner is chosen. The bench provokes this by pulsing done_i while other qualified requests are still high. It does this in fixed mode and in rotating mode, both in directed steps and at random. It expects the new acknowledge in the very next cycle, with hold request never dropping, and it expects the winner to follow the pointer just moved to the channel that finished. A reference model in the bench, driven by the same stimulus, gives the expected hrq_o, dack_o and active_ch_o for every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SERVE = 2'd2,
    ST_REL   = 2'd3
  } arb_state_e;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] valid_i,
  input  logic [CW-1:0]  last_i,
  input  logic           rotate_i,
  output logic           found_o,
  output logic [CW-1:0]  idx_o
);
  // candidate order: position k is the k-th channel to be tried
  logic [CW-1:0]  cand [NCH];
  logic [NCH-1:0] hit;

  for (genvar k = 0; k < NCH; k++) begin : g_cand
    assign cand[k] = rotate_i ? CW'((32'(last_i) + 32'(k) + 32'd1) % NCH)
                              : CW'(k);
    assign hit[k]  = valid_i[cand[k]];
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found_o = 1'b1;
        idx_o   = cand[k];
      end
    end
  end
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] valid_i,
  input  logic           hlda_i,
  input  logic           done_i,
  input  logic           pick_found_i,
  input  logic [CW-1:0]  pick_idx_i,
  output arb_state_e     state_o,
  output logic [CW-1:0]  last_o,
  output logic           hrq_o,
  output logic [NCH-1:0] dack_o,
  output logic [CW-1:0]  ch_o
);
  arb_state_e     st_q, st_d;
  logic           hrq_q, hrq_d;
  logic [NCH-1:0] dack_q, dack_d;
  logic [CW-1:0]  ch_q, ch_d;
  logic [CW-1:0]  last_q;
  logic           last_en;
  logic           any_valid;
  logic [NCH-1:0] grant_vec;

  assign any_valid = |valid_i;
  assign grant_vec = NCH'(1) << pick_idx_i;
  assign last_en   = (st_q == ST_SERVE) && done_i;

  always_comb begin
    st_d   = st_q;
    hrq_d  = hrq_q;
    dack_d = dack_q;
    ch_d   = ch_q;
    case (st_q)
      ST_IDLE: begin
        if (any_valid) begin
          hrq_d = 1'b1;
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (hlda_i) begin
          if (pick_found_i) begin
            dack_d = grant_vec;
            ch_d   = pick_idx_i;
            st_d   = ST_SERVE;
          end else begin
            hrq_d = 1'b0;
            st_d  = ST_REL;
          end
        end else if (!any_valid) begin
          hrq_d = 1'b0;
          st_d  = ST_IDLE;
        end
      end
      ST_SERVE: begin
        if (done_i) begin
          if (pick_found_i) begin
            dack_d = grant_vec;
            ch_d   = pick_idx_i;
          end else begin
            dack_d = '0;
            hrq_d  = 1'b0;
            st_d   = ST_REL;
          end
        end
      end
      ST_REL: begin
        if (!hlda_i) st_d = ST_IDLE;
      end
      default: begin
        st_d   = ST_IDLE;
        hrq_d  = 1'b0;
        dack_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hrq_q  <= 1'b0;
      dack_q <= '0;
      ch_q   <= '0;
    end else begin
      st_q   <= st_d;
      hrq_q  <= hrq_d;
      dack_q <= dack_d;
      ch_q   <= ch_d;
    end
  end

  // pointer reset to the top channel so that channel 0 is tried first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= CW'(NCH - 1);
    else if (last_en) last_q <= ch_q;
  end

  assign state_o = st_q;
  assign last_o  = last_q;
  assign hrq_o   = hrq_q;
  assign dack_o  = dack_q;
  assign ch_o    = ch_q;

  p_onehot_dack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_q));
  p_dack_needs_hlda_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack_q) |-> hlda_i);
  p_grant_after_hlda_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERVE && $past(st_q) == ST_WAIT) |-> $past(hlda_i));
  p_grant_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dack_q) && dack_q != $past(dack_q)) |-> (|($past(valid_i) & dack_q)));
  p_release_no_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REL) |-> (!hrq_q && dack_q == '0));
  p_channel_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack_q) |-> dack_q[ch_q]);
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] chan_en_i,
  input  logic           rotate_i,
  input  logic           hlda_i,
  input  logic           done_i,
  output logic           hrq_o,
  output logic [NCH-1:0] dack_o,
  output logic           active_o,
  output logic [CW-1:0]  active_ch_o
);
  logic           rst_n_s;
  logic [NCH-1:0] valid;
  logic           pick_found;
  logic [CW-1:0]  pick_idx;
  logic [CW-1:0]  pick_base;
  logic [CW-1:0]  last_ch;
  logic [CW-1:0]  cur_ch;
  arb_state_e     state;

  assign valid = req_i & chan_en_i;
  // on a done edge the finished channel becomes the new pointer at once
  assign pick_base = (state == ST_SERVE) ? cur_ch : last_ch;

  dma_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .valid_i  (valid),
    .last_i   (pick_base),
    .rotate_i (rotate_i),
    .found_o  (pick_found),
    .idx_o    (pick_idx)
  );

  dma_bus_fsm #(.NCH(NCH)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .valid_i      (valid),
    .hlda_i       (hlda_i),
    .done_i       (done_i),
    .pick_found_i (pick_found),
    .pick_idx_i   (pick_idx),
    .state_o      (state),
    .last_o       (last_ch),
    .hrq_o        (hrq_o),
    .dack_o       (dack_o),
    .ch_o         (cur_ch)
  );

  assign active_o    = (state == ST_SERVE);
  assign active_ch_o = cur_ch;

  p_hold_from_valid_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_IDLE && (|valid)) |=> hrq_o);
  p_active_has_dack_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    active_o |-> (dack_o != '0));
endmodule

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;
  logic       clk;
  logic       rst_n;
  logic [3:0] req;
  logic [3:0] en;
  logic       rot;
  logic       hlda;
  logic       done;
  logic       hrq;
  logic [3:0] dack;
  logic       active;
  logic [1:0] active_ch;

  int checks;
  int failures;
  bit finished;

  // reference model state: 0 idle, 1 wait, 2 serve, 3 release
  int         m_st;
  logic       m_hrq;
  logic [3:0] m_dack;
  int         m_ch;
  int         m_last;

  dma_req_arbiter u0 (
    .clk (clk), .rst_n (rst_n), .req_i (req), .chan_en_i (en),
    .rotate_i (rot), .hlda_i (hlda), .done_i (done),
    .hrq_o (hrq), .dack_o (dack), .active_o (active), .active_ch_o (active_ch)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int pick(logic [3:0] v, int last, logic rotating);
    for (int k = 0; k < 4; k++) begin
      int c;
      c = rotating ? (last + 1 + k) % 4 : k;
      if (v[c]) return c;
    end
    return -1;
  endfunction

  function automatic void model_step();
    logic [3:0] v;
    int w;
    v = req & en;
    case (m_st)
      0: if (v != 0) begin m_hrq = 1'b1; m_st = 1; end
      1: begin
        if (hlda) begin
          w = pick(v, m_last, rot);
          if (w >= 0) begin m_dack = 4'b0001 << w; m_ch = w; m_st = 2; end
          else begin m_hrq = 1'b0; m_st = 3; end
        end else if (v == 0) begin
          m_hrq = 1'b0; m_st = 0;
        end
      end
      2: if (done) begin
        m_last = m_ch;
        w = pick(v, m_last, rot);
        if (w >= 0) begin m_dack = 4'b0001 << w; m_ch = w; end
        else begin m_dack = 4'b0000; m_hrq = 1'b0; m_st = 3; end
      end
      default: if (!hlda) m_st = 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    chk(tag, "hrq", int'(hrq), int'(m_hrq));
    chk(tag, "dack", int'(dack), int'(m_dack));
    chk(tag, "active", int'(active), int'(m_st == 2));
    if (m_st == 2) chk("R11", "active_ch", int'(active_ch), m_ch);
    chk("R5", "dack_onehot0", int'($countones(dack) <= 1), 1);
    if (dack != 0) chk("R5", "hlda_with_dack", int'(hlda), 1);
  endtask

  // drive at a falling edge, advance the model, check after the next rise
  task automatic cyc(logic [3:0] r, logic [3:0] e, logic ro, logic h,
                     logic d, string tag);
    req = r; en = e; rot = ro; hlda = h; done = d;
    model_step();
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    checks = 0; failures = 0; finished = 1'b0;
    req = '0; en = '0; rot = 1'b0; hlda = 1'b0; done = 1'b0;
    m_st = 0; m_hrq = 1'b0; m_dack = '0; m_ch = 0; m_last = 3;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "hrq_in_reset", int'(hrq), 0);
    chk("R1", "dack_in_reset", int'(dack), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R1");

    // R2: disabled requests are ignored
    repeat (3) cyc(4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0, "R2");
    // R3: one enabled channel raises hold
    cyc(4'b1111, 4'b0100, 1'b0, 1'b0, 1'b0, "R3");
    // R4: no grant without hold acknowledge, then grant of channel 2
    repeat (2) cyc(4'b1111, 4'b0100, 1'b0, 1'b0, 1'b0, "R4");
    cyc(4'b1111, 4'b0100, 1'b0, 1'b1, 1'b0, "R4");
    chk("R2", "masked_winner", int'(dack), 4'b0100);
    // R9: service ends with nothing left, bus released
    cyc(4'b0000, 4'b0100, 1'b0, 1'b1, 1'b1, "R9");
    cyc(4'b1111, 4'b1111, 1'b0, 1'b1, 1'b0, "R9");
    chk("R9", "no_rehold_while_hlda", int'(hrq), 0);
    cyc(4'b1010, 4'b1111, 1'b0, 1'b0, 1'b0, "R9");
    cyc(4'b1010, 4'b1111, 1'b0, 1'b0, 1'b0, "R9");
    chk("R9", "rehold_after_hlda_low", int'(hrq), 1);
    // R6: fixed priority picks channel 1
    cyc(4'b1010, 4'b1111, 1'b0, 1'b1, 1'b0, "R6");
    chk("R6", "fixed_winner", int'(dack), 4'b0010);
    // R8: done with requests left, fixed keeps channel 1
    cyc(4'b1010, 4'b1111, 1'b0, 1'b1, 1'b1, "R8");
    chk("R8", "regrant_hold_kept", int'(hrq), 1);
    // R7: rotating after channel 1 -> 3, then after 3 -> 0
    cyc(4'b1011, 4'b1111, 1'b1, 1'b1, 1'b1, "R7");
    chk("R7", "rotate_after_1", int'(dack), 4'b1000);
    cyc(4'b1011, 4'b1111, 1'b1, 1'b1, 1'b1, "R7");
    chk("R7", "rotate_wrap", int'(dack), 4'b0001);
    // R10: requests vanish while waiting for the bus
    cyc(4'b0000, 4'b1111, 1'b0, 1'b1, 1'b1, "R10");
    cyc(4'b0000, 4'b1111, 1'b0, 1'b0, 1'b0, "R10");
    cyc(4'b0001, 4'b0001, 1'b0, 1'b0, 1'b0, "R10");
    cyc(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, "R10");
    chk("R10", "hold_dropped", int'(hrq), 0);

    // random phase: CPU follows hold request with random latency
    for (int i = 0; i < 4000; i++) begin
      logic h;
      logic d;
      logic ro;
      h = hlda;
      if (hrq && !hlda && ($urandom % 10) < 4) h = 1'b1;
      if (!hrq && hlda && ($urandom % 10) < 5) h = 1'b0;
      d  = (m_st == 2) && (($urandom % 10) < 3);
      ro = (($urandom % 16) == 0) ? ~rot : rot;
      cyc(4'($urandom), 4'($urandom | 32'h1), ro, h, d, ro ? "R7" : "R6");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule